// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block forms the signed product of two two's-complement operands of width `W` (default 8) by walking the multiplier one bit per clock with radix-2 Booth recoding. A single-cycle `start` pulse, given while the block is idle, captures both operands. The block then runs exactly `W` recoding steps and raises `done` for one cycle. At that point the `2W`-bit signed product is valid on `product`.

The datapath has four pieces of state. An upper accumulator is one bit wider than the operands. A lower accumulator holds the low half of the product. A multiplier register rotates rather than draining. A single history bit holds the multiplier bit examined on the previous step.

Each step compares the current low multiplier bit with the history bit:
- When they are equal, the step only shifts.
- When the current bit is 0 and the history bit is 1, the step adds the multiplicand into the upper half.
- When the current bit is 1 and the history bit is 0, the step subtracts the multiplicand from the upper half.

After that decision, the upper and lower halves shift right arithmetically as one unit. A parameter selects how subtraction is built: either as a native difference or as an addition of the inverted multiplicand with a carry-in of one.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is held and just after it, `busy` is 0, `done` is 0 and `product` is 0.
- R2: A `start` seen high at a clock edge while `busy` is 0 captures `mcand` and `mplier`. From that edge, `busy` reads 1 and `product` reads 0.
- R3: When `done` is 1, `product` equals the signed product of the captured operands, as a `2W`-bit two's-complement value. This holds for every operand pair, including both operands at the most negative value.
- R4: `busy` stays high for exactly `W` clock cycles after the capturing edge. `done` rises on the same edge at which `busy` falls, so `done` is first seen `W` edges after the capturing edge.
- R5: `done` is high for exactly one cycle per accepted start.
- R6: A `start` that arrives while `busy` is 1 is ignored. It changes neither the result nor the completion timing of the operation in progress.
- R7: While `busy` is 0 and no start is accepted, `product` keeps its value, whatever `mcand` and `mplier` do.
- R8: Changes on `mcand` and `mplier` after the capturing edge have no effect on the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; accepted only while idle |
| mcand | input | W | Signed multiplicand, captured on an accepted start |
| mplier | input | W | Signed multiplier, captured on an accepted start |
| busy | output | 1 | High while recoding steps are running |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2W | Signed product, held until the next accepted start |

## Verification
Any error in the history bit, the rotation of the multiplier register or the add/subtract choice corrupts only some operand patterns. Such an error surfaces as a wrong `product` on the `done` cycle, `W` cycles after the start. For this reason the bench sweeps every operand pair of a 6-bit instance, most-negative corners included. A missing accumulator guard bit shows only on the most-negative multiplicand. An off-by-one step counter shows at once as `done` arriving a cycle early or late, and as a product off by a factor of two. Ignored-start and operand-change faults are exposed by poking `start` and the operand inputs mid-run, then checking the result and the latency.

// File: rtl/booth_pkg.sv
package booth_pkg;

   // Action chosen by the recoder for one step
   typedef enum logic [1:0] {
      BOP_HOLD = 2'd0,   // shift only
      BOP_ADD  = 2'd1,   // add multiplicand to upper half
      BOP_SUB  = 2'd2    // subtract multiplicand from upper half
   } booth_op_e;

endpackage

// File: rtl/booth_recode.sv
module booth_recode
   import booth_pkg::*;
(
   input  logic      cur_bit,
   input  logic      hist_bit,
   output booth_op_e op
);

   always_comb begin
      unique case ({cur_bit, hist_bit})
         2'b01:   op = BOP_ADD;   // end of a run of ones
         2'b10:   op = BOP_SUB;   // start of a run of ones
         default: op = BOP_HOLD;  // inside a run: shift only
      endcase
   end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
   import booth_pkg::*;
#(
   parameter int WA        = 9,
   parameter int SUB_STYLE = 0   // 0: native difference, 1: invert plus carry-in
)(
   input  logic [WA-1:0] acc,
   input  logic [WA-1:0] addend,
   input  booth_op_e     op,
   output logic [WA-1:0] res
);

   logic [WA-1:0] diff;

   generate
      if (SUB_STYLE == 0) begin : g_sub_native
         assign diff = acc - addend;
      end else begin : g_sub_invert
         assign diff = acc + ~addend + {{(WA-1){1'b0}}, 1'b1};
      end
   endgenerate

   always_comb begin
      unique case (op)
         BOP_ADD: res = acc + addend;
         BOP_SUB: res = diff;
         default: res = acc;
      endcase
   end

endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl #(
   parameter int STEPS = 8
)(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);

   localparam int CW = $clog2(STEPS + 1);

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          done_q;

   assign load = start & ~busy_q;
   assign step = busy_q;
   assign busy = busy_q;
   assign done = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (busy_q) begin
            if (cnt_q == CW'(STEPS - 1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
   import booth_pkg::*;
#(
   parameter int W         = 8,
   parameter int SUB_STYLE = 0
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [W-1:0]   mcand,
   input  logic [W-1:0]   mplier,
   output logic           busy,
   output logic           done,
   output logic [2*W-1:0] product
);

   // Upper half carries one guard bit so that subtracting the most
   // negative multiplicand cannot wrap before the arithmetic shift.
   localparam int WA = W + 1;

   generate
      if (W < 2) begin : g_bad_width
         $error("booth_seq_mul: W must be at least 2");
      end
      if (SUB_STYLE < 0 || SUB_STYLE > 1) begin : g_bad_style
         $error("booth_seq_mul: SUB_STYLE must be 0 or 1");
      end
   endgenerate

   logic          load, step;
   booth_op_e     op;
   logic [WA-1:0] hi_q, mcx_q, sum;
   logic [W-1:0]  lo_q, mul_q;
   logic          hist_q;

   booth_seq_ctrl #(.STEPS(W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .busy  (busy),
      .done  (done)
   );

   booth_recode u_rec (
      .cur_bit  (mul_q[0]),
      .hist_bit (hist_q),
      .op       (op)
   );

   booth_addsub #(.WA(WA), .SUB_STYLE(SUB_STYLE)) u_as (
      .acc    (hi_q),
      .addend (mcx_q),
      .op     (op),
      .res    (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         mul_q  <= '0;
         mcx_q  <= '0;
         hist_q <= 1'b0;
      end else if (load) begin
         hi_q   <= '0;
         lo_q   <= '0;
         mul_q  <= mplier;
         mcx_q  <= {mcand[W-1], mcand};
         hist_q <= 1'b0;
      end else if (step) begin
         // arithmetic right shift of {upper, lower} after the add/sub
         hi_q   <= {sum[WA-1], sum[WA-1:1]};
         lo_q   <= {sum[0], lo_q[W-1:1]};
         // remember the bit just examined, then rotate the multiplier
         hist_q <= mul_q[0];
         mul_q  <= {mul_q[0], mul_q[W-1:1]};
      end
   end

   assign product = {hi_q[W-1:0], lo_q};

endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
   parameter int W = 8
)(
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic [W-1:0]   mcand,
   input logic [W-1:0]   mplier,
   input logic           busy,
   input logic           done,
   input logic [2*W-1:0] product
);

   logic signed [2*W-1:0] exp_q;
   logic [15:0]           bcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q  <= '0;
         bcnt_q <= '0;
      end else begin
         if (start && !busy)
            exp_q <= $signed({{W{mcand[W-1]}}, mcand}) * $signed({{W{mplier[W-1]}}, mplier});
         bcnt_q <= busy ? bcnt_q + 16'd1 : 16'd0;
      end
   end

   // R2: accepted start clears product and raises busy
   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && product == '0));

   // R3: product correct when done
   a_r3_product: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($signed(product) == exp_q));

   // R4: busy lasts W cycles and done coincides with its fall
   a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (bcnt_q == 16'(W) && done));

   // R5: done is a single-cycle pulse
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: product held while idle and no start
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(product));

endmodule

bind booth_seq_mul booth_seq_mul_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .mcand   (mcand),
   .mplier  (mplier),
   .busy    (busy),
   .done    (done),
   .product (product)
);

// File: tb/sim_booth_seq_mul.sv
`timescale 1ns/1ps
module sim_booth_seq_mul;

   localparam int W = 6;

   logic           clk = 1'b0;
   logic           rst_n;
   logic           start;
   logic [W-1:0]   mcand, mplier;
   logic           busy, done;
   logic [2*W-1:0] product;

   int nchk = 0;
   int nerr = 0;
   bit finished = 0;

   always #2 clk = ~clk;   // 250 MHz

   booth_seq_mul #(.W(W), .SUB_STYLE(1)) u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .mcand   (mcand),
      .mplier  (mplier),
      .busy    (busy),
      .done    (done),
      .product (product)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_op(input int a, input int b, input bit poke);
      int     lat;
      longint exp, got;
      logic [2*W-1:0] held;
      string  req;
      exp = longint'(a) * longint'(b);
      req = poke ? "R3 R6 R8" : "R3";
      mcand  = a[W-1:0];
      mplier = b[W-1:0];
      start  = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat   = 1;
      check(busy == 1'b1, "R2 busy", longint'(busy), 1);
      check(product == '0, "R2 product", longint'(product), 0);
      if (poke) begin
         mcand  = mcand ^ {W{1'b1}};
         mplier = mplier ^ {W{1'b1}};
      end
      while (!done && lat < 3*W) begin
         @(negedge clk);
         lat++;
         start = (poke && lat == 3) ? 1'b1 : 1'b0;
         if (!done) check(busy == 1'b1, "R4 busy held", longint'(busy), 1);
      end
      start = 1'b0;
      check(lat == W + 1, poke ? "R4 R6 latency" : "R4 latency", lat, W + 1);
      check(busy == 1'b0, "R4 busy low at done", longint'(busy), 0);
      got = longint'($signed(product));
      check(got == exp, req, got, exp);
      held   = product;
      mcand  = ~a[W-1:0];
      mplier = b[W-1:0] + 1'b1;
      @(negedge clk);
      check(done == 1'b0, "R5", longint'(done), 0);
      check(product == held, "R7", longint'(product), longint'(held));
   endtask

   initial begin
      rst_n  = 1'b0;
      start  = 1'b0;
      mcand  = '0;
      mplier = '0;
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R1 busy", longint'(busy), 0);
      check(done == 1'b0, "R1 done", longint'(done), 0);
      check(product == '0, "R1 product", longint'(product), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(product == '0 && busy == 1'b0, "R1 after release", longint'(product), 0);

      // corners first: most negative operands
      run_op(-(1 << (W-1)), -(1 << (W-1)), 1'b0);
      run_op(-(1 << (W-1)), (1 << (W-1)) - 1, 1'b0);
      run_op((1 << (W-1)) - 1, -(1 << (W-1)), 1'b1);

      // exhaustive sweep
      for (int a = -(1 << (W-1)); a < (1 << (W-1)); a++) begin
         for (int b = -(1 << (W-1)); b < (1 << (W-1)); b++) begin
            run_op(a, b, ((a + b) & 3) == 0);
         end
      end

      // R7: longer idle with wiggling inputs
      begin
         logic [2*W-1:0] keep;
         keep = product;
         for (int i = 0; i < 5; i++) begin
            mcand  = mcand + 3'd5;
            mplier = mplier ^ 6'h2A;
            @(negedge clk);
            check(product == keep, "R7 idle", longint'(product), longint'(keep));
         end
      end

      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         nchk++;
         nerr++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

endmodule